// File: doc/BRIEF.md
# Relative Branch Target Unit

This block resolves a conditional relative branch for an 8-bit processor with a 16-bit program counter. A request carries three things: the address where the branch opcode sits, the one-byte displacement that follows it, and a 4-bit condition selector. The current N, Z, V and C condition-code bits come in with it. One clock later the block reports whether the branch is taken and which program counter value comes next.

A branch always takes two bytes, so the fall-through address is the opcode address plus two. The displacement is a two's-complement byte: bit 7 set means it points backwards. It is added to the fall-through address, not to the opcode address. The sum wraps modulo 2^16.

Control is a two-state machine. `ST_IDLE` means no result is being presented. `ST_RESULT` means the registered result is valid.
- `ST_IDLE` moves to `ST_RESULT` when a request strobe arrives.
- `ST_RESULT` stays in `ST_RESULT` while strobes continue back to back, and loads a new result on each one.
- `ST_RESULT` returns to `ST_IDLE` when the strobe is low.

The result registers keep their last value until the next strobe.

Top module: `branch_target_unit`

## Requirements
- R1: After reset `rsp_valid`, `rsp_taken` and `next_pc` are all zero.
- R2: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low after a cycle with `req_valid` low.
- R3: When the branch is not taken, `next_pc` equals `op_addr + 2` modulo 2^16 (0xFFFF gives 0x0001).
- R4: When the branch is taken, `next_pc` equals `op_addr + 2 + offset`. Here `offset` is sign-extended from bit 7 to 16 bits (0x80 = -128, 0x7F = +127) and the sum wraps modulo 2^16.
- R5: Selector 0 (always) is always taken. Selectors 9 to 15 are never taken.
- R6: Selector 1 is taken when `flag_z` is 1. Selector 2 is taken when `flag_z` is 0.
- R7: Selector 3 is taken when `flag_c` is 1. Selector 4 is taken when `flag_c` is 0.
- R8: Selector 5 is taken when `flag_n` is 1. Selector 6 is taken when `flag_n` is 0.
- R9: Selector 7 is taken when `flag_v` is 1. Selector 8 is taken when `flag_v` is 0.
- R10: In a cycle with `req_valid` low, changes on the other inputs do not alter `rsp_taken` or `next_pc`.
- R11: Requests on consecutive cycles each produce their own result on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| op_addr | input | 16 | Address of the branch opcode |
| offset | input | 8 | Signed displacement byte |
| cond_sel | input | 4 | Condition selector |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| rsp_valid | output | 1 | Result valid |
| rsp_taken | output | 1 | Branch taken |
| next_pc | output | 16 | Next program counter |

## Verification
The first sweep covers every selector against all sixteen N/Z/V/C combinations. This shows that each condition reads the right flag with the right polarity, and that unused codes never fire.

The second sweep covers all 256 displacement bytes from opcode addresses at zero, in the middle, near the sign boundary and at the top of memory. It separates correct sign extension and the +2 base from zero-extension or an opcode-address base, and it covers wrap-around in both directions.

The requests run back to back. After them the bench holds the strobe low while the inputs change, to show that results are retained.

// File: rtl/bru_pkg.sv
package bru_pkg;
    localparam int PC_W       = 16;
    localparam int OFF_W      = 8;
    localparam int SEL_W      = 4;
    localparam int INSN_BYTES = 2;

    typedef enum logic [SEL_W-1:0] {
        COND_ALWAYS = 4'd0,
        COND_EQ     = 4'd1,
        COND_NE     = 4'd2,
        COND_CS     = 4'd3,
        COND_CC     = 4'd4,
        COND_MI     = 4'd5,
        COND_PL     = 4'd6,
        COND_VS     = 4'd7,
        COND_VC     = 4'd8
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESULT
    } fsm_e;
endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
    import bru_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic [SW-1:0] sel,
    input  flags_t        flags,
    output logic          take
);
    always_comb begin
        unique case (sel)
            COND_ALWAYS: take = 1'b1;
            COND_EQ:     take = flags.z;
            COND_NE:     take = ~flags.z;
            COND_CS:     take = flags.c;
            COND_CC:     take = ~flags.c;
            COND_MI:     take = flags.n;
            COND_PL:     take = ~flags.n;
            COND_VS:     take = flags.v;
            COND_VC:     take = ~flags.v;
            default:     take = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_target_calc.sv
module bru_target_calc #(
    parameter int AW    = 16,
    parameter int OW    = 8,
    parameter int STEP  = 2
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] disp,
    output logic [AW-1:0] fall_thru,
    output logic [AW-1:0] target
);
    logic [AW-1:0] disp_ext;

    generate
        if (OW < AW) begin : g_sext
            assign disp_ext = {{(AW-OW){disp[OW-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[AW-1:0];
        end
    endgenerate

    assign fall_thru = base + AW'(STEP);
    assign target    = fall_thru + disp_ext;
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
    import bru_pkg::*;
#(
    parameter int AW   = PC_W,
    parameter int OW   = OFF_W,
    parameter int SW   = SEL_W,
    parameter int STEP = INSN_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] op_addr,
    input  logic [OW-1:0] offset,
    input  logic [SW-1:0] cond_sel,
    input  logic          flag_n,
    input  logic          flag_z,
    input  logic          flag_v,
    input  logic          flag_c,
    output logic          rsp_valid,
    output logic          rsp_taken,
    output logic [AW-1:0] next_pc
);
    fsm_e          state_q, state_d;
    flags_t        flags;
    logic          take_c;
    logic [AW-1:0] fall_c, tgt_c;

    assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

    bru_cond_eval #(.SW(SW)) u_cond (
        .sel   (cond_sel),
        .flags (flags),
        .take  (take_c)
    );

    bru_target_calc #(.AW(AW), .OW(OW), .STEP(STEP)) u_tgt (
        .base      (op_addr),
        .disp      (offset),
        .fall_thru (fall_c),
        .target    (tgt_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)  state_d = ST_RESULT;
            ST_RESULT: if (!req_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_taken <= 1'b0;
            next_pc   <= '0;
        end else if (req_valid) begin
            rsp_taken <= take_c;
            next_pc   <= take_c ? tgt_c : fall_c;
        end
    end

    assign rsp_valid = (state_q == ST_RESULT);
endmodule

// File: rtl/bru_checker.sv
module bru_checker #(
    parameter int AW = 16,
    parameter int OW = 8,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] op_addr,
    input logic [OW-1:0] offset,
    input logic [SW-1:0] cond_sel,
    input logic          flag_z,
    input logic          rsp_valid,
    input logic          rsp_taken,
    input logic [AW-1:0] next_pc
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_fall_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_taken || next_pc == $past(op_addr) + AW'(2)));
    assert_taken_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_taken ||
            next_pc == $past(op_addr) + AW'(2) + {{(AW-OW){$past(offset[OW-1])}}, $past(offset)}));
    assert_always_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cond_sel == SW'(0)) |=> rsp_taken);
    assert_eq_on_z_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cond_sel == SW'(1)) |=> (rsp_taken == $past(flag_z)));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(next_pc) && $stable(rsp_taken)));
endmodule

bind branch_target_unit bru_checker #(.AW(AW), .OW(OW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .op_addr   (op_addr),
    .offset    (offset),
    .cond_sel  (cond_sel),
    .flag_z    (flag_z),
    .rsp_valid (rsp_valid),
    .rsp_taken (rsp_taken),
    .next_pc   (next_pc)
);

// File: tb/branch_target_unit_tb.sv
module branch_target_unit_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] op_addr = '0;
    logic [7:0]  offset = '0;
    logic [3:0]  cond_sel = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic        rsp_valid, rsp_taken;
    logic [15:0] next_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    branch_target_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_addr(op_addr),
        .offset(offset), .cond_sel(cond_sel), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .rsp_valid(rsp_valid),
        .rsp_taken(rsp_taken), .next_pc(next_pc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_take(input logic [3:0] s, input logic [3:0] f);
        // f = {n, z, v, c}
        case (s)
            4'd0: return 1'b1;
            4'd1: return f[2];
            4'd2: return !f[2];
            4'd3: return f[0];
            4'd4: return !f[0];
            4'd5: return f[3];
            4'd6: return !f[3];
            4'd7: return f[1];
            4'd8: return !f[1];
            default: return 1'b0;
        endcase
    endfunction

    function automatic string sel_tag(input logic [3:0] s);
        if (s == 4'd1 || s == 4'd2) return "R6";
        if (s == 4'd3 || s == 4'd4) return "R7";
        if (s == 4'd5 || s == 4'd6) return "R8";
        if (s == 4'd7 || s == 4'd8) return "R9";
        return "R5";
    endfunction

    // Drive one request at a falling edge, then check its result at the next falling edge.
    task automatic issue(input logic [15:0] a, input logic [7:0] o,
                         input logic [3:0] s, input logic [3:0] f);
        logic        t;
        logic [15:0] ft, tg, ex;
        op_addr = a; offset = o; cond_sel = s;
        {flag_n, flag_z, flag_v, flag_c} = f;
        req_valid = 1'b1;
        t  = exp_take(s, f);
        ft = a + 16'd2;
        tg = ft + {{8{o[7]}}, o};
        ex = t ? tg : ft;
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R11", int'(rsp_valid), 1);
        chk(rsp_taken == t, sel_tag(s), int'(rsp_taken), int'(t));
        chk(next_pc == ex, t ? "R4" : "R3", int'(next_pc), int'(ex));
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] addrs [5];
        logic [15:0] hold_pc;
        logic        hold_t;
        addrs[0] = 16'h0000; addrs[1] = 16'h0010; addrs[2] = 16'h7FFE;
        addrs[3] = 16'hFFFE; addrs[4] = 16'hFFFF;

        repeat (2) @(negedge clk);
        // R1: reset values
        chk(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);
        chk(rsp_taken == 1'b0, "R1", int'(rsp_taken), 0);
        chk(next_pc == 16'h0000, "R1", int'(next_pc), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", int'(rsp_valid), 0);

        // Example: opcode at 10, offset 15, equal with Z set and clear
        issue(16'd10, 8'd15, 4'd1, 4'b0100);
        chk(next_pc == 16'd27, "R4", int'(next_pc), 27);
        issue(16'd10, 8'd15, 4'd1, 4'b0000);
        chk(next_pc == 16'd12, "R3", int'(next_pc), 12);

        // Selector x flag sweep (R5..R9), back to back (R11)
        for (int s = 0; s < 16; s++) begin
            for (int f = 0; f < 16; f++) begin
                issue(16'h1000 + 16'(s * 37 + f), 8'(f * 17), 4'(s), 4'(f));
            end
        end

        // Offset sweep, taken (R4) and never-taken (R3), with wrap
        for (int ai = 0; ai < 5; ai++) begin
            for (int o = 0; o < 256; o++) begin
                issue(addrs[ai], 8'(o), 4'd0, 4'd0);
            end
            issue(addrs[ai], 8'h80, 4'd15, 4'hF);
        end
        issue(16'hFFFF, 8'h00, 4'd9, 4'd0);
        chk(next_pc == 16'h0001, "R3", int'(next_pc), 1);
        issue(16'h0000, 8'h80, 4'd0, 4'd0);
        chk(next_pc == 16'hFF82, "R4", int'(next_pc), 16'hFF82);

        // R10 / R2: strobe low, inputs change, results held
        hold_pc = next_pc;
        hold_t  = rsp_taken;
        req_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            op_addr = 16'(16'h2222 * (k + 1));
            offset = 8'(k * 50);
            cond_sel = 4'(k + 1);
            {flag_n, flag_z, flag_v, flag_c} = 4'(~k);
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R2", int'(rsp_valid), 0);
            chk(next_pc == hold_pc, "R10", int'(next_pc), int'(hold_pc));
            chk(rsp_taken == hold_t, "R10", int'(rsp_taken), int'(hold_t));
        end

        // Restart after idle gap
        issue(16'h4000, 8'hFE, 4'd2, 4'b0000);
        req_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", int'(rsp_valid), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule